// File: doc/BRIEF.md
# Timer Compare/Capture Channel Unit

One channel of a general-purpose timer. The channel owns a single general register. A 4-bit mode code sets that register up in one of two ways. As an output-compare register, it watches an external free-running counter and drives a pin when the counter reaches the register value. As an input-capture register, it records the counter value when an event occurs. The event is either an edge on a capture pin or a count event from a neighbouring channel. The counter itself and its clock prescaling come from outside the block.

Software writes the mode code, the register and a flag-clear strobe through one shared write port. In compare mode the pin starts from an initial level that the mode code programs. On each match the pin is cleared, set or toggled. A sticky flag reports every match or capture. A buffer-mode input marks the register as serving as a buffer, and while it is high no match or capture takes effect.

Top module: `timer_chan_unit`

## Requirements
- R1: After reset the mode code is 0000, `pinOe` is 0, `flagOut` is 0 and `regOut` is 0.
- R2: With mode code 0000 or 0100, `pinOe` is 0. A match still sets the flag.
- R3: Writing a compare code (bit 3 = 0, bits 1:0 not 00) sets `pinOe` to 1 and loads `pinOut` with bit 2 of the code on the clock edge of the write.
- R4: A match occurs when `cntVal` equals the register on a clock edge. The pin changes on that same edge: code bits 1:0 = 01 drive 0, 10 drive 1, and 11 toggle the pin.
- R5: The flag is sticky. A match or capture sets it, and a write with `wrSel` = 2 clears it. If a set and a clear arrive on the same edge, the set wins.
- R6: Code 1000 captures `cntVal` into the register on a rising edge of `capPin`. The capture happens on the third clock edge after the pin changes, because the pin passes two synchroniser stages first.
- R7: Code 1001 captures on a falling edge of `capPin` only. A rising edge is ignored.
- R8: Codes 1010 and 1011 capture on both edges of `capPin`.
- R9: Codes 11xx capture on every edge where `nbrCount` is high, and ignore `capPin`.
- R10: While `bufMode` is 1, no match or capture takes effect. The flag, the pin and the register are left unchanged by counter events.
- R11: A register write (`wrSel` = 1) in compare mode is visible on `regOut` one edge later. In capture mode the write is ignored.
- R12: In any capture code, `pinOe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntVal | input | CNT_W | Free-running counter value |
| capPin | input | 1 | Asynchronous capture pin |
| nbrCount | input | 1 | Neighbour-channel count-up/down event, one cycle per count |
| bufMode | input | 1 | Register used as a buffer; suppresses match and capture |
| wrEn | input | 1 | Write strobe |
| wrSel | input | 2 | Write target: 0 mode code, 1 register, 2 flag clear |
| wrData | input | CNT_W | Write data; bits 3:0 carry the mode code |
| pinOut | output | 1 | Compare pin level |
| pinOe | output | 1 | Pin output enable |
| flagOut | output | 1 | Sticky match/capture flag |
| regOut | output | CNT_W | General register value |

## Verification
The assertions assume a single write per cycle on the shared port. They also assume that `capPin` is low when reset is released, so the synchroniser does not show a false rising edge. They further assume that `nbrCount` is a one-cycle event, not a level. The stimulus drives every input on the falling clock edge, so each input changes once per cycle. It releases reset with the capture pin low. It parks the counter on a value that differs from the register whenever a mode change could otherwise cause an unintended match.

// File: rtl/tcu_pkg.sv
package tcu_pkg;

  localparam logic [1:0] SEL_CODE = 2'd0;
  localparam logic [1:0] SEL_REG  = 2'd1;
  localparam logic [1:0] SEL_CLR  = 2'd2;

  typedef struct packed {
    logic loadInit;
    logic initLevel;
    logic pinClr;
    logic pinSet;
    logic pinTog;
    logic capture;
    logic setFlag;
    logic clrFlag;
    logic regWr;
  } tcu_strobe_t;

endpackage

// File: rtl/tcu_ctrl.sv
module tcu_ctrl
  import tcu_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cntVal,
  input  logic [CNT_W-1:0] regVal,
  input  logic             capPin,
  input  logic             nbrCount,
  input  logic             bufMode,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [3:0]       wrCode,
  output tcu_strobe_t      strobe,
  output logic             pinOe
);

  localparam int SHIFT_W = SYNC_STAGES + 1;

  logic [3:0]         ioCode;
  logic [SHIFT_W-1:0] capShift;
  logic               capNow, capPrev, riseEdge, fallEdge;
  logic               capMode, outEn, codeWr, match, capEvent;

  // mode code register
  always_ff @(posedge clk) begin
    if (!rstN) ioCode <= 4'b0000;
    else if (wrEn && wrSel == SEL_CODE) ioCode <= wrCode;
  end

  // pin synchroniser plus one history stage
  genvar gi;
  generate
    for (gi = 0; gi < SHIFT_W; gi++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rstN) capShift[gi] <= 1'b0;
        else if (gi == 0) capShift[gi] <= capPin;
        else capShift[gi] <= capShift[gi-1];
      end
    end
  endgenerate

  assign capNow   = capShift[SYNC_STAGES-1];
  assign capPrev  = capShift[SYNC_STAGES];
  assign riseEdge = capNow && !capPrev;
  assign fallEdge = !capNow && capPrev;

  assign capMode = ioCode[3];
  assign outEn   = !capMode && (ioCode[1:0] != 2'b00);
  assign codeWr  = wrEn && (wrSel == SEL_CODE);
  assign match   = !capMode && !bufMode && (cntVal == regVal);

  always_comb begin
    casez (ioCode[2:0])
      3'b000:  capEvent = riseEdge;
      3'b001:  capEvent = fallEdge;
      3'b01?:  capEvent = riseEdge || fallEdge;
      default: capEvent = nbrCount;
    endcase
  end

  always_comb begin
    strobe           = '0;
    strobe.loadInit  = codeWr && !wrCode[3] && (wrCode[1:0] != 2'b00);
    strobe.initLevel = wrCode[2];
    if (match && outEn && !codeWr) begin
      strobe.pinClr = (ioCode[1:0] == 2'b01);
      strobe.pinSet = (ioCode[1:0] == 2'b10);
      strobe.pinTog = (ioCode[1:0] == 2'b11);
    end
    strobe.capture = capMode && !bufMode && capEvent;
    strobe.setFlag = match || strobe.capture;
    strobe.clrFlag = wrEn && (wrSel == SEL_CLR);
    strobe.regWr   = wrEn && (wrSel == SEL_REG) && !capMode;
  end

  assign pinOe = outEn;

  // at most one pin action per edge
  assert_one_pin_action_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.pinClr, strobe.pinSet, strobe.pinTog}));

  // capture and register write never collide
  assert_no_cap_write_clash_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.capture && strobe.regWr));

endmodule

// File: rtl/tcu_datapath.sv
module tcu_datapath
  import tcu_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tcu_strobe_t      strobe,
  input  logic [CNT_W-1:0] cntVal,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] regVal,
  output logic             pinLvl,
  output logic             flag
);

  always_ff @(posedge clk) begin
    if (!rstN) regVal <= '0;
    else if (strobe.capture) regVal <= cntVal;
    else if (strobe.regWr) regVal <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) pinLvl <= 1'b0;
    else if (strobe.loadInit) pinLvl <= strobe.initLevel;
    else if (strobe.pinClr) pinLvl <= 1'b0;
    else if (strobe.pinSet) pinLvl <= 1'b1;
    else if (strobe.pinTog) pinLvl <= !pinLvl;
  end

  always_ff @(posedge clk) begin
    if (!rstN) flag <= 1'b0;
    else if (strobe.setFlag) flag <= 1'b1;
    else if (strobe.clrFlag) flag <= 1'b0;
  end

  assert_toggle_flips_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pinTog |=> pinLvl != $past(pinLvl));

  assert_capture_loads_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> (regVal == $past(cntVal)) && flag);

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setFlag |=> flag);

  assert_reg_write_R11: assert property (@(posedge clk) disable iff (!rstN)
    strobe.regWr |=> regVal == $past(wrData));

endmodule

// File: rtl/timer_chan_unit.sv
module timer_chan_unit
  import tcu_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cntVal,
  input  logic             capPin,
  input  logic             nbrCount,
  input  logic             bufMode,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [CNT_W-1:0] wrData,
  output logic             pinOut,
  output logic             pinOe,
  output logic             flagOut,
  output logic [CNT_W-1:0] regOut
);

  tcu_strobe_t strobe;

  tcu_ctrl #(.CNT_W(CNT_W), .SYNC_STAGES(2)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cntVal   (cntVal),
    .regVal   (regOut),
    .capPin   (capPin),
    .nbrCount (nbrCount),
    .bufMode  (bufMode),
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .wrCode   (wrData[3:0]),
    .strobe   (strobe),
    .pinOe    (pinOe)
  );

  tcu_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .cntVal (cntVal),
    .wrData (wrData),
    .regVal (regOut),
    .pinLvl (pinOut),
    .flag   (flagOut)
  );

  assert_init_level_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == SEL_CODE && !wrData[3] && wrData[1:0] != 2'b00)
      |=> pinOe && (pinOut == $past(wrData[2])));

  assert_buffer_no_flag_R10: assert property (@(posedge clk) disable iff (!rstN)
    (bufMode && !flagOut) |=> !flagOut);

  assert_buffer_pin_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (bufMode && !wrEn) |=> $stable(pinOut) && $stable(regOut));

endmodule

// File: tb/timer_chan_unit_bench.sv
module timer_chan_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam logic [W-1:0] IDLE = 16'hFFFF;
  localparam logic [W-1:0] CMPV = 16'h1234;

  // {code[3:0], oe, init, afterFirstMatch, afterSecondMatch}
  localparam logic [7:0] VEC [8] = '{
    8'b0000_0_0_0_0, 8'b0001_1_0_0_0, 8'b0010_1_0_1_1, 8'b0011_1_0_1_0,
    8'b0100_0_0_0_0, 8'b0101_1_1_0_0, 8'b0110_1_1_1_1, 8'b0111_1_1_0_1
  };

  logic clk = 1'b0, rstN = 1'b0;
  logic [W-1:0] cntVal = IDLE, wrData = '0;
  logic capPin = 1'b0, nbrCount = 1'b0, bufMode = 1'b0, wrEn = 1'b0;
  logic [1:0] wrSel = 2'd3;
  logic pinOut, pinOe, flagOut;
  logic [W-1:0] regOut;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  timer_chan_unit #(.CNT_W(W)) u_timer_chan_unit (
    .clk(clk), .rstN(rstN), .cntVal(cntVal), .capPin(capPin), .nbrCount(nbrCount),
    .bufMode(bufMode), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .pinOut(pinOut), .pinOe(pinOe), .flagOut(flagOut), .regOut(regOut));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [W-1:0] data);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    step(1);
    wrEn = 1'b0; wrSel = 2'd3;
  endtask

  task automatic matchOnce();
    cntVal = CMPV;
    step(1);
    cntVal = IDLE;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    // R1 reset state
    chk("R1 pinOe", pinOe, 0);
    chk("R1 flag", flagOut, 0);
    chk("R1 reg", regOut, 0);

    // table walk over compare codes: R2 R3 R4
    for (int v = 0; v < 8; v++) begin
      wr(2'd2, '0);
      wr(2'd0, {12'h0, VEC[v][7:4]});
      chk("R2/R3 pinOe", pinOe, VEC[v][3]);
      if (VEC[v][3]) chk("R3 init level", pinOut, VEC[v][2]);
      wr(2'd1, CMPV);
      chk("R11 reg write", regOut, CMPV);
      chk("R5 flag idle", flagOut, 0);
      matchOnce();
      chk("R2/R5 flag on match", flagOut, 1);
      if (VEC[v][3]) chk("R4 first match", pinOut, VEC[v][1]);
      wr(2'd2, '0);
      chk("R5 flag cleared", flagOut, 0);
      matchOnce();
      if (VEC[v][3]) chk("R4 second match", pinOut, VEC[v][0]);
    end

    // R5 set beats clear on the same edge
    wr(2'd0, 16'h0001);
    wrEn = 1'b1; wrSel = 2'd2; cntVal = CMPV;
    step(1);
    wrEn = 1'b0; wrSel = 2'd3; cntVal = IDLE;
    chk("R5 set wins", flagOut, 1);

    // R6 rising capture with synchroniser latency
    wr(2'd0, 16'h0008);
    wr(2'd2, '0);
    chk("R12 pinOe capture", pinOe, 0);
    cntVal = 16'h0ABC; capPin = 1'b1;
    step(2);
    chk("R6 no early capture", flagOut, 0);
    step(1);
    chk("R6 rise flag", flagOut, 1);
    chk("R6 rise value", regOut, 16'h0ABC);
    wr(2'd2, '0);
    cntVal = 16'h0DEF; capPin = 1'b0;
    step(3);
    chk("R6 fall ignored flag", flagOut, 0);
    chk("R6 fall ignored reg", regOut, 16'h0ABC);

    // R7 falling only
    wr(2'd0, 16'h0009);
    cntVal = 16'h0111; capPin = 1'b1;
    step(3);
    chk("R7 rise ignored", regOut, 16'h0ABC);
    cntVal = 16'h0222; capPin = 1'b0;
    step(3);
    chk("R7 fall value", regOut, 16'h0222);
    chk("R7 fall flag", flagOut, 1);

    // R8 both edges, low bit ignored
    wr(2'd0, 16'h000A);
    wr(2'd2, '0);
    cntVal = 16'h0333; capPin = 1'b1;
    step(3);
    chk("R8 rise value", regOut, 16'h0333);
    wr(2'd0, 16'h000B);
    wr(2'd2, '0);
    cntVal = 16'h0444; capPin = 1'b0;
    step(3);
    chk("R8 fall value", regOut, 16'h0444);
    chk("R8 flag", flagOut, 1);

    // R9 neighbour count event
    wr(2'd0, 16'h000E);
    wr(2'd2, '0);
    cntVal = 16'h0555; nbrCount = 1'b1;
    step(1);
    nbrCount = 1'b0;
    chk("R9 nbr value", regOut, 16'h0555);
    chk("R9 nbr flag", flagOut, 1);
    wr(2'd2, '0);
    cntVal = 16'h0666; capPin = 1'b1;
    step(3);
    chk("R9 pin ignored reg", regOut, 16'h0555);
    chk("R9 pin ignored flag", flagOut, 0);
    chk("R12 pinOe 11xx", pinOe, 0);

    // R11 register write ignored in capture mode
    wr(2'd1, 16'h5555);
    step(1);
    chk("R11 write ignored", regOut, 16'h0555);

    // R10 buffer mode suppresses capture and compare
    bufMode = 1'b1;
    wr(2'd0, 16'h0009);
    cntVal = 16'h0777; capPin = 1'b0;
    step(3);
    chk("R10 no capture reg", regOut, 16'h0555);
    chk("R10 no capture flag", flagOut, 0);
    cntVal = IDLE;
    wr(2'd0, 16'h0003);
    wr(2'd1, CMPV);
    matchOnce();
    chk("R10 pin held", pinOut, 0);
    chk("R10 no match flag", flagOut, 0);
    bufMode = 1'b0;
    matchOnce();
    chk("R10 released match", pinOut, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule